// File: doc/BRIEF.md
# Nested Interrupt Controller with Per-Level Mask Words

This block sits between five interrupt request lines and a simple CPU. Each request line is edge-latched into a pending bit. The block raises a single request with a source number. When the CPU acknowledges, that source moves onto an in-service stack. An end-of-service pulse from the CPU pops the stack.

Every source owns a mask word, and the CPU can rewrite it through a small register write port. While a source sits on top of the in-service stack, its mask word decides which sources may break into its service routine. The default words give plain fixed-priority nesting. Rewriting them rearranges the effective service order without changing the hardware. Among unmasked pending sources, the lowest-numbered one always wins. A global enable flag, written through the same port, must be set for any request to reach the CPU.

Top module: `nic_nested_ctrl`

## Requirements
- R1: After a synchronous active-low reset, no source is pending, the in-service stack is empty, the enable flag is 0, every mask word holds its default, and `irq_out` is 0.
- R2: A pending bit is set only when its request line goes from 0 to 1 between two clock edges. A line held high after its request was acknowledged does not make the source pending again.
- R3: `irq_out` is 1 exactly when the enable flag is 1, the stack is not full, and at least one pending source is not blocked by the active mask.
- R4: When several unblocked sources are pending, `irq_vec` gives the lowest source number, because source 0 has the highest fixed priority.
- R5: The active mask is the mask word of the source on top of the in-service stack. When the stack is empty, no source is blocked.
- R6: `ack` while `irq_out` is 1 clears the pending bit of `irq_vec` and pushes that source onto the stack. `ack` while `irq_out` is 0 has no effect.
- R7: `eoi` pops the stack, so the mask word of the source below becomes active again. `eoi` with an empty stack has no effect.
- R8: Mask bit i stands for source i (bit 0 = source 0). The default mask of source k has bits k up to 4 set, so each source blocks itself and every lower-priority source.
- R9: A write with `cfg_we` = 1 and `cfg_sel` from 0 to 4 loads `cfg_wdata` into that source's mask word. `cfg_sel` = 5 loads the enable flag from `cfg_wdata[0]`.
- R10: If `ack` and `eoi` are both 1 in the same cycle, the `eoi` is carried out and the `ack` is ignored.
- R11: With mask words 01001 for source 0, 11111 for source 1, 01101 for source 2, 01000 for source 3 and 11101 for source 4 (written bit 4 down to bit 0), the nesting order becomes 1, 4, 2, 0, 3. A source later in this order can always be pre-empted by one earlier in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 5 | Request lines, one per source, latched on a rising level |
| ack | input | 1 | CPU acknowledge of the offered source |
| eoi | input | 1 | CPU end-of-service pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Write target: 0-4 mask words, 5 enable flag |
| cfg_wdata | input | 5 | Write data |
| irq_out | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 3 | Number of the source offered to the CPU |

## Verification
With the default masks, the bench first lets a low-priority source be blocked during a higher service. It then lets a higher one nest and shows that the blocked source is released only once the stack unwinds. This separates a correct mask restore from a missing pop. Two sources raised together check the fixed-priority pick. Toggling the enable flag around a pending source shows that the offer is gated, and that an ignored acknowledge leaves the source pending. After the rearranged mask words are loaded, sources arrive in the reverse of the new order. Each one must nest, and a source raised deep in the stack stays held until every entry that blocks it has been popped.

// File: rtl/nic_pkg.sv
// Shared helpers for the nested interrupt controller.
// Assumes source count stays small (one mask word per source).
package nic_pkg;

    // Default mask of source k in an n-source system: blocks k and all lower priorities.
    function automatic logic [31:0] nic_default_mask(input int k, input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            if (i >= k) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nic_req_latch.sv
// Request latch: turns 0->1 transitions on each line into sticky pending bits.
// Assumes request lines are synchronous to clk.
module nic_req_latch #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pending
);
    logic [NUM_SRC-1:0] prev_q;

    // Track previous line level and set/clear pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pending <= '0;
        end else begin
            prev_q  <= irq_in;
            pending <= (pending & ~clr) | (irq_in & ~prev_q);
        end
    end

    // A newly set pending bit needs its line high in the previous cycle.
    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & ~$past(pending)) & ~$past(irq_in)) == '0);

endmodule

// File: rtl/nic_mask_bank.sv
// Mask word bank and global enable flag, loaded through a simple write port.
// Assumes select codes 0..NUM_SRC-1 address masks and NUM_SRC addresses the enable flag.
module nic_mask_bank
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_SRC-1:0]         wdata,
    output logic [NUM_SRC*NUM_SRC-1:0] mask_flat,
    output logic                       ie
);
    localparam logic [SEL_W-1:0] SEL_IE = SEL_W'(NUM_SRC);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_mask
        localparam logic [NUM_SRC-1:0] DEF = NUM_SRC'(nic_default_mask(k, NUM_SRC));
        logic [NUM_SRC-1:0] word_q;

        // Hold one source's mask word; reload default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                            word_q <= DEF;
            else if (we && sel == SEL_W'(k))       word_q <= wdata;
        end

        assign mask_flat[k*NUM_SRC +: NUM_SRC] = word_q;
    end

    // Global interrupt enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ie <= 1'b0;
        else if (we && sel == SEL_IE)  ie <= wdata[0];
    end

    // Enable flag only changes through an enable-select write.
    p_ie_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we && sel == SEL_IE) |-> $stable(ie));

endmodule

// File: rtl/nic_svc_stack.sv
// In-service stack: holds source numbers of nested service routines, NUM_SRC deep.
// Assumes the caller never pushes when full and never pops when empty.
module nic_svc_stack #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] top_idx,
    output logic             empty,
    output logic             full
);
    localparam int DEP_W = $clog2(NUM_SRC + 1);

    logic [IDX_W-1:0] slot_q [NUM_SRC];
    logic [DEP_W-1:0] depth_q;
    logic [DEP_W-1:0] top_ptr;

    assign empty   = (depth_q == '0);
    assign full    = (depth_q == DEP_W'(NUM_SRC));
    assign top_ptr = empty ? '0 : depth_q - DEP_W'(1);
    assign top_idx = slot_q[top_ptr];

    // Update depth counter on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                 depth_q <= '0;
        else if (pop && !empty)     depth_q <= depth_q - DEP_W'(1);
        else if (push && !full)     depth_q <= depth_q + DEP_W'(1);
    end

    // Write the pushed source number into the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) slot_q[i] <= '0;
        end else if (push && !pop && !full) begin
            slot_q[depth_q] <= push_idx;
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> depth_q == $past(depth_q) + DEP_W'(1));
    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> empty);

endmodule

// File: rtl/nic_prio_pick.sv
// Fixed-priority picker: lowest-numbered eligible source wins.
// Purely combinational.
module nic_prio_pick #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from lowest priority up so the lowest index is kept last.
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/nic_nested_ctrl.sv
// Nested interrupt controller: per-source mask words decide pre-emption while
// a source is in service; fixed priority picks among unblocked pending sources.
// Assumes ack and eoi are single-cycle pulses from the CPU.
module nic_nested_ctrl #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int SEL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               ack,
    input  logic               eoi,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [NUM_SRC-1:0] cfg_wdata,
    output logic               irq_out,
    output logic [IDX_W-1:0]   irq_vec
);
    logic [NUM_SRC-1:0]         pending, clr, active_mask, elig;
    logic [NUM_SRC*NUM_SRC-1:0] mask_flat;
    logic                       ie, any, do_ack, do_pop, st_empty, st_full;
    logic [IDX_W-1:0]           top_idx;

    nic_req_latch #(.NUM_SRC(NUM_SRC)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(clr), .pending(pending)
    );

    nic_mask_bank #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .mask_flat(mask_flat), .ie(ie)
    );

    nic_svc_stack #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(do_ack), .push_idx(irq_vec), .pop(do_pop),
        .top_idx(top_idx), .empty(st_empty), .full(st_full)
    );

    nic_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .any(any), .idx(irq_vec)
    );

    // Select the mask word of the top in-service source, none when idle.
    always_comb begin
        active_mask = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (!st_empty && top_idx == IDX_W'(k)) active_mask = mask_flat[k*NUM_SRC +: NUM_SRC];
        end
    end

    // Gate the request and decode the CPU handshake.
    always_comb begin
        elig    = pending & ~active_mask;
        irq_out = ie && any && !st_full;
        do_pop  = eoi && !st_empty;
        do_ack  = ack && irq_out && !eoi;
        clr     = do_ack ? (NUM_SRC'(1) << irq_vec) : '0;
    end

    p_irq_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ie);
    p_vec_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pending[irq_vec]);
    p_vec_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !active_mask[irq_vec]);
    p_ack_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && eoi) |-> !do_ack);

endmodule

// File: tb/nic_nested_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected outputs after each cycle,
// a monitor pops and compares them away from the active edge.
module nic_nested_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       irq;
        logic [2:0] vec;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] irq_in = '0;
    logic       ack = 1'b0, eoi = 1'b0, cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [4:0] cfg_wdata = '0;
    logic       irq_out;
    logic [2:0] irq_vec;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_nested_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .eoi(eoi),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .irq_out(irq_out), .irq_vec(irq_vec)
    );

    // Drive one cycle of inputs at the falling edge, return after the rising edge.
    task automatic tick(input logic [4:0] irq, input logic a, input logic e,
                        input logic we, input logic [2:0] sel, input logic [4:0] wd);
        @(negedge clk);
        irq_in = irq; ack = a; eoi = e; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        @(posedge clk);
    endtask

    task automatic drv(input logic [4:0] irq);               tick(irq, 0, 0, 0, 3'd0, 5'd0); endtask
    task automatic do_ack(input logic [4:0] irq);            tick(irq, 1, 0, 0, 3'd0, 5'd0); endtask
    task automatic do_eoi(input logic [4:0] irq);            tick(irq, 0, 1, 0, 3'd0, 5'd0); endtask
    task automatic wr(input logic [4:0] irq, input logic [2:0] s, input logic [4:0] d);
        tick(irq, 0, 0, 1, s, d);
    endtask

    // Queue the expected outputs for the next sampling point.
    task automatic expect_out(input string tag, input logic irq, input logic [2:0] vec);
        exp_t item;
        item.irq = irq; item.vec = vec; item.tag = tag;
        exp_q.push_back(item);
    endtask

    // Monitor: compare outputs at the falling edge against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t item;
                item = exp_q.pop_front();
                n_checks++;
                if (irq_out !== item.irq || (item.irq && irq_vec !== item.vec)) begin
                    n_errors++;
                    $display("FAIL %s: irq_out=%0b irq_vec=%0d expected irq_out=%0b irq_vec=%0d",
                             item.tag, irq_out, irq_vec, item.irq, item.vec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) drv(5'b00000);
        @(negedge clk); rst_n = 1'b1;
        drv(5'b00000);              expect_out("R1 reset quiet", 0, 0);
        drv(5'b00100);              expect_out("R1 enable clear after reset", 0, 0);
        wr(5'b00100, 3'd5, 5'd1);   expect_out("R9 enable write offers L2", 1, 2);
        do_ack(5'b00100);           expect_out("R6 ack clears pending", 0, 0);
        drv(5'b10100);              expect_out("R8 L2 default blocks L4", 0, 0);
        drv(5'b10110);              expect_out("R5 L1 may pre-empt L2", 1, 1);
        do_ack(5'b10110);           expect_out("R8 L1 default blocks L4", 0, 0);
        do_eoi(5'b10110);           expect_out("R7 pop restores L2 mask", 0, 0);
        do_eoi(5'b10110);           expect_out("R7 empty stack frees L4", 1, 4);
        do_eoi(5'b10110);           expect_out("R7 eoi on empty stack ignored", 1, 4);
        tick(5'b10110, 1, 1, 0, 3'd0, 5'd0); expect_out("R10 ack with eoi ignored", 1, 4);
        do_ack(5'b10110);           expect_out("R6 ack L4", 0, 0);
        do_eoi(5'b10110);           expect_out("R2 held lines do not re-pend", 0, 0);
        drv(5'b00000);              expect_out("R2 lines low", 0, 0);
        drv(5'b01010);              expect_out("R4 L1 beats L3", 1, 1);
        wr(5'b01010, 3'd5, 5'd0);   expect_out("R3 enable off gates request", 0, 0);
        do_ack(5'b01010);           expect_out("R6 ack without request ignored", 0, 0);
        wr(5'b01010, 3'd5, 5'd1);   expect_out("R6 L1 still pending", 1, 1);
        do_ack(5'b01010);           expect_out("R8 L1 blocks L3", 0, 0);
        do_eoi(5'b01010);           expect_out("R7 L3 released", 1, 3);
        do_ack(5'b01010);           expect_out("R6 ack L3", 0, 0);
        do_eoi(5'b01010);           expect_out("R7 stack empty", 0, 0);
        drv(5'b00000);              expect_out("R3 idle", 0, 0);

        wr(5'b00000, 3'd0, 5'b01001); expect_out("R9 load mask L0", 0, 0);
        wr(5'b00000, 3'd1, 5'b11111); expect_out("R9 load mask L1", 0, 0);
        wr(5'b00000, 3'd2, 5'b01101); expect_out("R9 load mask L2", 0, 0);
        wr(5'b00000, 3'd3, 5'b01000); expect_out("R9 load mask L3", 0, 0);
        wr(5'b00000, 3'd4, 5'b11101); expect_out("R9 load mask L4", 0, 0);

        drv(5'b01000);              expect_out("R11 L3 offered", 1, 3);
        do_ack(5'b01000);           expect_out("R11 L3 in service", 0, 0);
        drv(5'b00001);              expect_out("R11 L0 pre-empts L3", 1, 0);
        do_ack(5'b00001);           expect_out("R11 L0 in service", 0, 0);
        drv(5'b00100);              expect_out("R11 L2 pre-empts L0", 1, 2);
        do_ack(5'b00100);           expect_out("R11 L2 in service", 0, 0);
        drv(5'b10000);              expect_out("R11 L4 pre-empts L2", 1, 4);
        do_ack(5'b10000);           expect_out("R11 L4 in service", 0, 0);
        drv(5'b00010);              expect_out("R11 L1 pre-empts L4", 1, 1);
        do_ack(5'b00010);           expect_out("R11 stack full", 0, 0);
        do_eoi(5'b00010);           expect_out("R7 back to L4", 0, 0);
        drv(5'b00011);              expect_out("R11 L4 blocks L0", 0, 0);
        do_eoi(5'b00011);           expect_out("R7 L2 mask blocks L0", 0, 0);
        do_eoi(5'b00011);           expect_out("R7 L0 mask blocks L0", 0, 0);
        do_eoi(5'b00011);           expect_out("R7 L3 mask frees L0", 1, 0);
        do_ack(5'b00011);           expect_out("R6 ack L0 again", 0, 0);
        do_eoi(5'b00011);           expect_out("R7 pop to L3", 0, 0);
        do_eoi(5'b00011);           expect_out("R7 stack drained", 0, 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule